// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address sequence of a four-beat memory burst. When a burst opens, a load strobe captures a full starting address. After that, every accepted advance request moves the burst one beat on. The two low address bits follow either a counting order or an XOR-based order, chosen by a static mode pin. The upper address bits stay frozen at the values captured by the load.

The advance input is active low. While it is high the address holds, which lets the consumer insert wait states. Advance has no effect on the edge that loads a new address. After the fourth beat the sequence returns to the starting address and never carries into the upper bits. The block holds no data, decodes no chip select and drives no memory array. It only supplies the address and the beat number to the logic around it.

Top module: `burst_addr_gen`

## Requirements
- R1: A rising edge with `rst_n` low sets `addr_o` and `beat_o` to zero. Reset is synchronous and active low.
- R2: A rising edge with `load_i` high captures `load_addr_i`. From the next cycle `addr_o` equals that address and `beat_o` is 0, in both modes.
- R3: With `interleave_i` low (counting order), `addr_o[1:0]` equals (start + `beat_o`) mod 4, where start is bits [1:0] of the loaded address.
- R4: With `interleave_i` high (XOR order), `addr_o[1:0]` equals start XOR `beat_o`.
- R5: On an edge without load, `beat_o` increases by one when `adv_n_i` is low (0 means advance). It holds its value when `adv_n_i` is high.
- R6: An advance taken from beat 3 returns `beat_o` to 0 and the low address bits to the start value. Bits above bit 1 are not changed by it.
- R7: On an edge with `load_i` high, `adv_n_i` is ignored: `beat_o` is 0 afterwards even if `adv_n_i` was low.
- R8: Between loads, `addr_o[ADDR_W-1:2]` keeps the value captured by the last load (or zero after reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | High: start a burst at `load_addr_i` |
| load_addr_i | input | ADDR_W | Starting address of the burst |
| adv_n_i | input | 1 | Low: advance one beat (ignored on a load edge) |
| interleave_i | input | 1 | 0: counting order, 1: XOR order (static per burst) |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | BEAT_W | Beat index within the burst, 0 to 3 |

## Verification
The directed sweep loads each of the four start values in both modes and steps through five beats. This exposes any mix-up between the counting and XOR orders, because the two orders differ only for odd starts at beats 1 and 3. It also catches a missing wrap. Loads with advance held low probe whether advance leaks through on the load edge. Random bursts with random wait states and random upper address bits cover holding, stepping and any carry into the frozen upper bits. A reset applied in the middle of a burst checks the return to zero.

// File: rtl/burst_pkg.sv
// Shared types for the burst address sequencer.
// Assumes: ordering selection is a single static bit.
package burst_pkg;
    typedef enum logic {
        ORD_COUNT = 1'b0,
        ORD_XOR   = 1'b1
    } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
// Beat counter: cleared by a load, stepped by an active-low advance,
// wraps modulo 2**BEAT_W. Assumes load has priority over advance.
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_n_i,
    output logic [BEAT_W-1:0] beat_o
);
    logic [BEAT_W-1:0] beat_q;

    // Update the beat index: reset, load clears, advance steps with natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat_q <= '0;
        else if (load_i)
            beat_q <= '0;
        else if (!adv_n_i)
            beat_q <= beat_q + 1'b1;
    end

    assign beat_o = beat_q;

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> $stable(beat_o));

    // R6
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i) |=> (beat_o == BEAT_W'($past(beat_o) + 1'b1)));

    // R7
    load_clears_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (beat_o == '0));
endmodule

// File: rtl/burst_order_map.sv
// Maps the start offset and beat index to the low address bits.
// Counting order adds modulo 2**BEAT_W; XOR order combines bit by bit.
// Purely combinational.
module burst_order_map #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0]    start_i,
    input  logic [BEAT_W-1:0]    beat_i,
    input  burst_pkg::order_e    order_i,
    output logic [BEAT_W-1:0]    low_o
);
    logic [BEAT_W-1:0] sum_w;
    logic [BEAT_W-1:0] xor_w;

    assign sum_w = start_i + beat_i;

    // One XOR per address bit of the burst field.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
        assign xor_w[b] = start_i[b] ^ beat_i[b];
    end

    // Select the ordering requested by the mode.
    always_comb begin
        low_o = (order_i == burst_pkg::ORD_XOR) ? xor_w : sum_w;
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Burst address sequencer top. Captures a start address on load,
// freezes its upper bits and orders the low bits by mode.
// Assumes the mode pin is stable during a burst.
module burst_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              adv_n_i,
    input  logic              interleave_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BEAT_W-1:0] beat_o
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic [UP_W-1:0]   upper_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_w;
    logic [BEAT_W-1:0] low_w;
    burst_pkg::order_e order_w;

    // Capture the starting address when a burst opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
        end else if (load_i) begin
            upper_q <= load_addr_i[ADDR_W-1:BEAT_W];
            start_q <= load_addr_i[BEAT_W-1:0];
        end
    end

    assign order_w = interleave_i ? burst_pkg::ORD_XOR : burst_pkg::ORD_COUNT;

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_n_i (adv_n_i),
        .beat_o  (beat_w)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .start_i (start_q),
        .beat_i  (beat_w),
        .order_i (order_w),
        .low_o   (low_w)
    );

    assign addr_o = {upper_q, low_w};
    assign beat_o = beat_w;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (addr_o == '0 && beat_o == '0));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(load_addr_i)));

    // R8
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
    localparam int AW = 16;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [AW-1:0] load_addr_i = '0;
    logic          adv_n_i = 1'b1;
    logic          interleave_i = 1'b0;
    logic [AW-1:0] addr_o;
    logic [BW-1:0] beat_o;

    int n_chk = 0;
    int n_bad = 0;

    // Reference state, updated from the requirements
    logic [AW-1:0] m_base = '0;
    int            m_beat = 0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) i_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_addr_i(load_addr_i),
        .adv_n_i(adv_n_i), .interleave_i(interleave_i),
        .addr_o(addr_o), .beat_o(beat_o)
    );

    function automatic logic [1:0] exp_low(logic [1:0] s, int b, logic xo);
        logic [1:0] bb = b[1:0];
        return xo ? (s ^ bb) : 2'(s + bb);
    endfunction

    function automatic logic [AW-1:0] exp_addr(logic xo);
        return {m_base[AW-1:2], exp_low(m_base[1:0], m_beat, xo)};
    endfunction

    task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: apply inputs, update the model, compare after the edge.
    task automatic cyc(logic rst, logic ld, logic [AW-1:0] a, logic adv_n, logic xo,
                       string tag);
        rst_n = rst; load_i = ld; load_addr_i = a; adv_n_i = adv_n; interleave_i = xo;
        @(posedge clk);
        if (!rst) begin
            m_base = '0; m_beat = 0;
        end else if (ld) begin
            m_base = a; m_beat = 0;
        end else if (!adv_n) begin
            m_beat = (m_beat + 1) % 4;
        end
        #1;
        check({tag, xo ? " R4 addr" : " R3 addr"}, addr_o, exp_addr(xo));
        check({tag, " R5 beat"}, AW'(beat_o), AW'(m_beat));
        check({tag, " R8 upper"}, AW'(addr_o[AW-1:2]), AW'(m_base[AW-1:2]));
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int seed;
        logic [AW-1:0] ad;
        seed = 1234;
        void'($urandom(seed));
        // R1: reset state
        cyc(1'b0, 1'b0, '0, 1'b1, 1'b0, "R1 reset");
        cyc(1'b0, 1'b0, '0, 1'b1, 1'b0, "R1 reset");
        check("R1 addr zero", addr_o, '0);

        // Directed: all starts, both modes, four beats then wrap (R3, R4, R6)
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                ad = {14'h2A5C, 2'(s)};
                cyc(1'b1, 1'b1, ad, 1'b1, 1'(m), "R2 load");
                check("R2 loaded addr", addr_o, ad);
                for (int b = 1; b < 4; b++)
                    cyc(1'b1, 1'b0, '0, 1'b0, 1'(m), "R3R4 step");
                cyc(1'b1, 1'b0, '0, 1'b0, 1'(m), "R6 wrap");
                check("R6 wrap to start", addr_o, ad);
                check("R6 beat zero", AW'(beat_o), '0);
            end
        end

        // R7: advance low on the load edge is ignored
        ad = 16'hFFFF;
        cyc(1'b1, 1'b0, '0, 1'b0, 1'b0, "R7 pre");
        cyc(1'b1, 1'b1, ad, 1'b0, 1'b0, "R7 load");
        check("R7 beat after load", AW'(beat_o), '0);
        check("R7 addr after load", addr_o, ad);
        // R6: wrap from 11 with all-ones upper bits does not carry
        for (int b = 0; b < 4; b++)
            cyc(1'b1, 1'b0, '0, 1'b0, 1'b0, "R6 nocarry");
        check("R6 no carry", addr_o, 16'hFFFF);
        // R5: wait states hold
        cyc(1'b1, 1'b0, '0, 1'b0, 1'b1, "R5 step");
        for (int w = 0; w < 3; w++)
            cyc(1'b1, 1'b0, '0, 1'b1, 1'b1, "R5 hold");
        check("R5 held beat", AW'(beat_o), AW'(1));

        // Random bursts with wait states
        for (int k = 0; k < 200; k++) begin
            logic xo;
            xo = 1'($urandom());
            cyc(1'b1, 1'b1, 16'($urandom()), 1'($urandom()), xo, "R2 rload");
            for (int c = 0; c < 12; c++)
                cyc(1'b1, ($urandom() % 16) == 0, 16'($urandom()),
                    1'($urandom()), xo, "rand");
            if (k == 100) cyc(1'b0, 1'b0, '0, 1'b0, xo, "R1 midreset");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule